// File: doc/BRIEF.md
# Multi-Processor Reset Generator with Cause Capture

This block produces the reset and externally initiated reset (XIR) signals for a system with four processors. Software reaches it through a small byte-wide register port. A write can pulse reset into chosen processors or into the whole system. Another write can send XIR to chosen processors. The block also watches a set of hardware request lines: a watchdog expiry, a reset push button, an XIR push button, JTAG reset and XIR requests, fatal-error reports from seven agents, a remote-monitor request and a clock-synthesizer load strobe. It turns each of these into a fixed-length reset or XIR pulse.

Two cause registers record what triggered the latest event. One covers power-on style resets and the other covers XIR. Each cause has a fixed bit. Only the true power-up input clears these registers, so software can read the cause after the system reset that it recorded. A watchdog enable, a synthesizer-reset enable and per-agent fatal-error masks decide which hardware causes are allowed to act.

Top module: `rstgen_ctrl`

## Requirements
- R1: After power-up (`pwr_n` low, then high), all reset and XIR outputs are low. The reset cause register reads 0x000080 (bit 7, power-up). The XIR cause register and all configuration registers read zero.
- R2: A write to address 0 with data bits 3:0 set drives `cpu_rst[i]` high for each set bit i. The pulse lasts exactly PULSE_LEN (16) cycles, starting at the clock edge that takes the write. `sys_rst` stays low.
- R3: A write to address 0 with bit 4 set drives `sys_rst` and all four `cpu_rst` lines high for PULSE_LEN cycles.
- R4: A write to address 1 with bits 3:0 set drives `cpu_xir[i]` high for PULSE_LEN cycles for each set bit.
- R5: A rising edge on `jtag_por_req`, `btn_por` or `rmon_req`, or on an unmasked `fatal_err` line, causes a system reset pulse.
- R6: A rising edge on `wdog_expire` causes a system reset only when bit 0 of address 2 is 1. A rising edge on `synth_load` causes one only when bit 7 of address 4 is 1. When the enable bit is clear, the line is ignored.
- R7: Bits 7:4 of address 3 mask `fatal_err[0]` to `fatal_err[3]` in that order. `fatal_err[6:4]` cannot be masked.
- R8: The reset cause register is read as bytes at addresses 8, 9 and 10 (bits 7:0, 15:8 and 17:16). Its encoding is:
  - bits 3:0: soft per-processor reset
  - bit 4: soft system reset
  - bit 5: JTAG
  - bit 6: push button
  - bit 7: power-up
  - bits 14:8: fatal error from agents 0 to 6
  - bit 15: synthesizer load
  - bit 16: watchdog
  - bit 17: remote monitor

  On every reset event, the register is replaced by the set of causes active in that cycle. Without an event it holds its value.
- R9: The XIR cause register at address 11 uses this encoding:
  - bits 3:0: soft XIR per processor
  - bit 4: JTAG XIR
  - bit 5: XIR button

  A JTAG XIR request or the XIR button pulses all four `cpu_xir` lines. The register is replaced on each XIR event.
- R10: Reserved bits read as zero and writes to them have no effect. The soft request registers (addresses 0 and 1) always read zero. A write of 0xE0 to address 0 triggers nothing.
- R11: Request inputs are edge-sensitive. A line held high acts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_n | input | 1 | True power-up reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wdog_expire | input | 1 | Watchdog timer expiry |
| btn_por | input | 1 | Reset push button |
| btn_xir | input | 1 | XIR push button |
| jtag_por_req | input | 1 | JTAG system reset request |
| jtag_xir_req | input | 1 | JTAG XIR request |
| fatal_err | input | 7 | Fatal-error reports, one per agent |
| rmon_req | input | 1 | Remote monitor reset request |
| synth_load | input | 1 | Clock-synthesizer load strobe |
| cpu_rst | output | 4 | Per-processor reset |
| cpu_xir | output | 4 | Per-processor XIR |
| sys_rst | output | 1 | Whole-system reset |

## Verification
The assertions take for granted that the request inputs and the register port are synchronous to `clk` and stable around its edge. They also assume that `pwr_n` is the only way the cause registers return to their power-up value. The stimulus changes every input on the falling edge. It drives each request for a single cycle, except where level-holding is the point of the test. It leaves at least PULSE_LEN plus four idle cycles between events, so each pulse-length check sees one isolated pulse.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int N_CPU   = 4;
  localparam int N_AGENT = 7;
  localparam int PSRC_W  = 18;
  localparam int XSRC_W  = 6;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_SOFT_POR = 4'd0;
  localparam logic [ADDR_W-1:0] A_SOFT_XIR = 4'd1;
  localparam logic [ADDR_W-1:0] A_WDOG     = 4'd2;
  localparam logic [ADDR_W-1:0] A_FMASK    = 4'd3;
  localparam logic [ADDR_W-1:0] A_SYNTH    = 4'd4;
  localparam logic [ADDR_W-1:0] A_PSRC0    = 4'd8;
  localparam logic [ADDR_W-1:0] A_PSRC1    = 4'd9;
  localparam logic [ADDR_W-1:0] A_PSRC2    = 4'd10;
  localparam logic [ADDR_W-1:0] A_XSRC     = 4'd11;

  // cause bit positions (fixed encoding read by software)
  localparam int PB_SOFT_SYS = 4;
  localparam int PB_JTAG     = 5;
  localparam int PB_BUTTON   = 6;
  localparam int PB_PWRUP    = 7;
  localparam int PB_FATAL0   = 8;
  localparam int PB_SYNTH    = 15;
  localparam int PB_WDOG     = 16;
  localparam int PB_RMON     = 17;
  localparam int XB_JTAG     = 4;
  localparam int XB_BUTTON   = 5;

  localparam logic [PSRC_W-1:0] PSRC_PWRUP = PSRC_W'(1) << PB_PWRUP;

  // countdown step of a pulse stretcher: reload wins over decrement
  function automatic int unsigned stretch_next(int unsigned cur, logic load,
                                               int unsigned len);
    if (load)          return len;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

  // masked rising-edge detection
  function automatic logic [N_AGENT-1:0] fatal_events(logic [N_AGENT-1:0] rise,
                                                      logic [N_CPU-1:0] mask);
    return rise & ~{{(N_AGENT-N_CPU){1'b0}}, mask};
  endfunction
endpackage

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic pwr_n,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) cnt <= '0;
    else        cnt <= CW'(rstgen_pkg::stretch_next(32'(cnt), load, LEN));
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/rstgen_cfg.sv
module rstgen_cfg
  import rstgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 pwr_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic [PSRC_W-1:0]    por_src,
  input  logic [XSRC_W-1:0]    xir_src,
  output logic [N_CPU:0]       soft_por_req,
  output logic [N_CPU-1:0]     soft_xir_req,
  output logic                 wdog_en,
  output logic [N_CPU-1:0]     fmask,
  output logic                 synth_en,
  output logic [7:0]           rdata
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[6:5];

  // self-clearing soft requests: live only in the write cycle
  assign soft_por_req = (wr_en && addr == A_SOFT_POR) ? wdata[N_CPU:0]   : '0;
  assign soft_xir_req = (wr_en && addr == A_SOFT_XIR) ? wdata[N_CPU-1:0] : '0;

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) begin
      wdog_en  <= 1'b0;
      fmask    <= '0;
      synth_en <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_WDOG:  wdog_en  <= wdata[0];
        A_FMASK: fmask    <= wdata[7:4];
        A_SYNTH: synth_en <= wdata[7];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_WDOG:  rdata = {7'b0, wdog_en};
      A_FMASK: rdata = {fmask, 4'b0};
      A_SYNTH: rdata = {synth_en, 7'b0};
      A_PSRC0: rdata = por_src[7:0];
      A_PSRC1: rdata = por_src[15:8];
      A_PSRC2: rdata = {6'b0, por_src[17:16]};
      A_XSRC:  rdata = {2'b0, xir_src};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 pwr_n,
  input  logic [N_CPU:0]       soft_por_req,
  input  logic [N_CPU-1:0]     soft_xir_req,
  input  logic                 wdog_en,
  input  logic [N_CPU-1:0]     fmask,
  input  logic                 synth_en,
  input  logic                 wdog_expire,
  input  logic                 btn_por,
  input  logic                 btn_xir,
  input  logic                 jtag_por_req,
  input  logic                 jtag_xir_req,
  input  logic [N_AGENT-1:0]   fatal_err,
  input  logic                 rmon_req,
  input  logic                 synth_load,
  output logic [PSRC_W-1:0]    por_evt,
  output logic [XSRC_W-1:0]    xir_evt,
  output logic [PSRC_W-1:0]    por_src,
  output logic [XSRC_W-1:0]    xir_src
);
  localparam int EXT_W = N_AGENT + 7;

  logic [EXT_W-1:0] ext_now, ext_prev, ext_rise;
  assign ext_now  = {fatal_err, rmon_req, synth_load, wdog_expire,
                     btn_xir, jtag_xir_req, btn_por, jtag_por_req};
  assign ext_rise = ext_now & ~ext_prev;

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) ext_prev <= '0;
    else        ext_prev <= ext_now;
  end

  always_comb begin
    por_evt                             = '0;
    por_evt[N_CPU:0]                    = soft_por_req;
    por_evt[PB_JTAG]                    = ext_rise[0];
    por_evt[PB_BUTTON]                  = ext_rise[1];
    por_evt[PB_FATAL0 +: N_AGENT]       = fatal_events(ext_rise[7 +: N_AGENT], fmask);
    por_evt[PB_SYNTH]                   = ext_rise[5] & synth_en;
    por_evt[PB_WDOG]                    = ext_rise[4] & wdog_en;
    por_evt[PB_RMON]                    = ext_rise[6];
    xir_evt                             = '0;
    xir_evt[N_CPU-1:0]                  = soft_xir_req;
    xir_evt[XB_JTAG]                    = ext_rise[2];
    xir_evt[XB_BUTTON]                  = ext_rise[3];
  end

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n) begin
      por_src <= PSRC_PWRUP;
      xir_src <= '0;
    end else begin
      if (|por_evt) por_src <= por_evt;
      if (|xir_evt) xir_src <= xir_evt;
    end
  end
endmodule

// File: rtl/rstgen_ctrl.sv
module rstgen_ctrl
  import rstgen_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               pwr_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               wdog_expire,
  input  logic               btn_por,
  input  logic               btn_xir,
  input  logic               jtag_por_req,
  input  logic               jtag_xir_req,
  input  logic [6:0]         fatal_err,
  input  logic               rmon_req,
  input  logic               synth_load,
  output logic [3:0]         cpu_rst,
  output logic [3:0]         cpu_xir,
  output logic               sys_rst
);
  logic [N_CPU:0]     soft_por_req;
  logic [N_CPU-1:0]   soft_xir_req;
  logic               wdog_en, synth_en;
  logic [N_CPU-1:0]   fmask;
  logic [PSRC_W-1:0]  por_evt, por_src;
  logic [XSRC_W-1:0]  xir_evt, xir_src;

  // named event wires for the checker
  logic               sys_evt;
  logic [N_CPU-1:0]   cpu_por_evt, cpu_xir_evt;
  logic [N_CPU-1:0]   cpu_pulse;

  rstgen_cfg u_cfg (
    .clk, .pwr_n, .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .por_src, .xir_src, .soft_por_req, .soft_xir_req,
    .wdog_en, .fmask, .synth_en, .rdata(reg_rdata)
  );

  rstgen_cause u_cause (
    .clk, .pwr_n, .soft_por_req, .soft_xir_req, .wdog_en, .fmask, .synth_en,
    .wdog_expire, .btn_por, .btn_xir, .jtag_por_req, .jtag_xir_req,
    .fatal_err, .rmon_req, .synth_load,
    .por_evt, .xir_evt, .por_src, .xir_src
  );

  assign sys_evt     = |por_evt[PSRC_W-1:N_CPU];
  assign cpu_por_evt = por_evt[N_CPU-1:0];
  assign cpu_xir_evt = xir_evt[N_CPU-1:0] | {N_CPU{|xir_evt[XSRC_W-1:N_CPU]}};

  rstgen_stretch #(.LEN(PULSE_LEN)) u_sys (
    .clk, .pwr_n, .load(sys_evt), .active(sys_rst)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    rstgen_stretch #(.LEN(PULSE_LEN)) u_por (
      .clk, .pwr_n, .load(cpu_por_evt[i]), .active(cpu_pulse[i])
    );
    rstgen_stretch #(.LEN(PULSE_LEN)) u_xir (
      .clk, .pwr_n, .load(cpu_xir_evt[i]), .active(cpu_xir[i])
    );
    assign cpu_rst[i] = cpu_pulse[i] | sys_rst;
  end
endmodule

// File: rtl/rstgen_ctrl_chk.sv
module rstgen_ctrl_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic        clk,
  input logic        pwr_n,
  input logic        sys_evt,
  input logic        sys_rst,
  input logic [3:0]  cpu_rst,
  input logic [17:0] por_evt,
  input logic [17:0] por_src,
  input logic [3:0]  reg_addr,
  input logic [7:0]  reg_rdata
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge pwr_n) begin
    if (!pwr_n)                       run <= '0;
    else if (!sys_rst)                run <= '0;
    else if (run <= RW'(PULSE_LEN))   run <= run + 1'b1;
  end

  // R3
  sys_evt_pulse_chk: assert property (@(posedge clk) disable iff (!pwr_n)
    sys_evt |=> (sys_rst && (&cpu_rst)));
  // R3
  sys_rise_cause_chk: assert property (@(posedge clk) disable iff (!pwr_n)
    $rose(sys_rst) |-> $past(sys_evt));
  // R3
  sys_len_chk: assert property (@(posedge clk) disable iff (!pwr_n)
    run <= RW'(PULSE_LEN));
  // R8
  psrc_load_chk: assert property (@(posedge clk) disable iff (!pwr_n)
    (|por_evt) |=> (por_src == $past(por_evt)));
  // R8
  psrc_hold_chk: assert property (@(posedge clk) disable iff (!pwr_n)
    !(|por_evt) |=> $stable(por_src));
  // R10
  xsrc_resv_chk: assert property (@(posedge clk) disable iff (!pwr_n)
    (reg_addr == 4'd11) |-> (reg_rdata[7:6] == 2'b00));
endmodule

bind rstgen_ctrl rstgen_ctrl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .pwr_n(pwr_n), .sys_evt(sys_evt), .sys_rst(sys_rst),
  .cpu_rst(cpu_rst), .por_evt(por_evt), .por_src(por_src),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/rstgen_ctrl_tb.sv
module rstgen_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PULSE = 16;

  logic clk = 1'b0;
  logic pwr_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic wdog_expire = 0, btn_por = 0, btn_xir = 0, jtag_por_req = 0;
  logic jtag_xir_req = 0, rmon_req = 0, synth_load = 0;
  logic [6:0] fatal_err = '0;
  logic [3:0] cpu_rst, cpu_xir;
  logic sys_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rstgen_ctrl #(.PULSE_LEN(PULSE)) u_dut (
    .clk, .pwr_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .wdog_expire, .btn_por, .btn_xir, .jtag_por_req, .jtag_xir_req,
    .fatal_err, .rmon_req, .synth_load, .cpu_rst, .cpu_xir, .sys_rst
  );

  // ext bits: [6]rmon [5]synth [4]wdog [3]btn_xir [2]jtag_xir [1]btn_por [0]jtag_por
  typedef struct packed {
    logic        wd;
    logic [3:0]  mask;
    logic        syn;
    logic [1:0]  sel;
    logic [4:0]  sdat;
    logic [6:0]  ext;
    logic [6:0]  fat;
    logic [17:0] epsrc;
    logic [5:0]  exsrc;
    logic [3:0]  ecpu;
    logic        esys;
    logic [3:0]  exir;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 1'b0, 2'd1, 5'h05, 7'h00, 7'h00, 18'h00005, 6'h00, 4'h5, 1'b0, 4'h0}, // R2
    '{1'b0, 4'h0, 1'b0, 2'd1, 5'h10, 7'h00, 7'h00, 18'h00010, 6'h00, 4'hF, 1'b1, 4'h0}, // R3
    '{1'b0, 4'h0, 1'b0, 2'd2, 5'h0A, 7'h00, 7'h00, 18'h00010, 6'h0A, 4'h0, 1'b0, 4'hA}, // R4
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h01, 7'h00, 18'h00020, 6'h0A, 4'hF, 1'b1, 4'h0}, // R5
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h02, 7'h20, 18'h02040, 6'h0A, 4'hF, 1'b1, 4'h0}, // R8
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h10, 7'h00, 18'h02040, 6'h0A, 4'h0, 1'b0, 4'h0}, // R6
    '{1'b1, 4'h0, 1'b0, 2'd0, 5'h00, 7'h10, 7'h00, 18'h10000, 6'h0A, 4'hF, 1'b1, 4'h0}, // R6
    '{1'b0, 4'h2, 1'b0, 2'd0, 5'h00, 7'h00, 7'h02, 18'h10000, 6'h0A, 4'h0, 1'b0, 4'h0}, // R7
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h00, 7'h02, 18'h00200, 6'h0A, 4'hF, 1'b1, 4'h0}, // R7
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h20, 7'h00, 18'h00200, 6'h0A, 4'h0, 1'b0, 4'h0}, // R6
    '{1'b0, 4'h0, 1'b1, 2'd0, 5'h00, 7'h20, 7'h00, 18'h08000, 6'h0A, 4'hF, 1'b1, 4'h0}, // R6
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h40, 7'h00, 18'h20000, 6'h0A, 4'hF, 1'b1, 4'h0}, // R5
    '{1'b0, 4'h0, 1'b0, 2'd0, 5'h00, 7'h0C, 7'h00, 18'h20000, 6'h30, 4'h0, 1'b0, 4'hF}, // R9
    '{1'b0, 4'hF, 1'b0, 2'd0, 5'h00, 7'h00, 7'h4F, 18'h04000, 6'h30, 4'hF, 1'b1, 4'h0}  // R7
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_psrc(output logic [17:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'd8, b0); rd(4'd9, b1); rd(4'd10, b2);
    v = {b2[1:0], b1, b0};
  endtask

  task automatic drive_ext(input logic [6:0] e, input logic [6:0] f);
    jtag_por_req = e[0]; btn_por = e[1]; jtag_xir_req = e[2]; btn_xir = e[3];
    wdog_expire = e[4]; synth_load = e[5]; rmon_req = e[6]; fatal_err = f;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [17:0] ps;
    repeat (3) @(negedge clk);
    pwr_n = 1'b1;
    @(negedge clk);

    // R1 power-up state
    check({27'b0, cpu_rst, sys_rst}, 32'h0, "R1 rst outputs");
    check({28'b0, cpu_xir}, 32'h0, "R1 xir outputs");
    rd_psrc(ps); check({14'b0, ps}, 32'h80, "R1 psrc");
    rd(4'd11, b); check({24'b0, b}, 32'h0, "R1 xsrc");
    rd(4'd2, b);  check({24'b0, b}, 32'h0, "R1 wdog cfg");

    for (int k = 0; k < NV; k++) begin
      wr(4'd2, {7'b0, VEC[k].wd});
      wr(4'd3, {VEC[k].mask, 4'b0});
      wr(4'd4, {VEC[k].syn, 7'b0});
      @(negedge clk);
      if (VEC[k].sel != 2'd0) begin
        reg_wr = 1'b1;
        reg_addr = (VEC[k].sel == 2'd1) ? 4'd0 : 4'd1;
        reg_wdata = {3'b0, VEC[k].sdat};
      end
      drive_ext(VEC[k].ext, VEC[k].fat);
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 8'h00;
      drive_ext(7'h00, 7'h00);
      check({27'b0, cpu_rst, sys_rst}, {27'b0, VEC[k].ecpu, VEC[k].esys},
            $sformatf("R2/R3/R5 vec%0d rst", k));
      check({28'b0, cpu_xir}, {28'b0, VEC[k].exir}, $sformatf("R4/R9 vec%0d xir", k));
      rd_psrc(ps);
      check({14'b0, ps}, {14'b0, VEC[k].epsrc}, $sformatf("R8 vec%0d psrc", k));
      rd(4'd11, b);
      check({24'b0, b}, {26'b0, VEC[k].exsrc}, $sformatf("R9 vec%0d xsrc", k));
      repeat (PULSE + 4) @(negedge clk);
    end
    wr(4'd3, 8'h00);

    // R2 pulse length exactly PULSE cycles
    wr(4'd0, 8'h01);
    check({31'b0, cpu_rst[0]}, 32'h1, "R2 pulse start");
    repeat (PULSE - 1) @(negedge clk);
    check({28'b0, cpu_rst}, 32'h1, "R2 pulse last cycle");
    @(negedge clk);
    check({28'b0, cpu_rst}, 32'h0, "R2 pulse ended");
    repeat (4) @(negedge clk);

    // R11 held level acts once
    jtag_por_req = 1'b1;
    @(negedge clk);
    check({31'b0, sys_rst}, 32'h1, "R11 first edge");
    repeat (PULSE + 10) @(negedge clk);
    check({31'b0, sys_rst}, 32'h0, "R11 level held no retrigger");
    jtag_por_req = 1'b0;
    rd_psrc(ps); check({14'b0, ps}, 32'h20, "R11 psrc");
    repeat (4) @(negedge clk);

    // R10 reserved bits
    wr(4'd0, 8'hE0);
    check({27'b0, cpu_rst, sys_rst}, 32'h0, "R10 reserved soft bits no reset");
    rd_psrc(ps); check({14'b0, ps}, 32'h20, "R10 psrc untouched");
    wr(4'd2, 8'hFF); rd(4'd2, b); check({24'b0, b}, 32'h01, "R10 wdog readback");
    wr(4'd3, 8'hFF); rd(4'd3, b); check({24'b0, b}, 32'hF0, "R10 fmask readback");
    wr(4'd4, 8'hFF); rd(4'd4, b); check({24'b0, b}, 32'h80, "R10 synth readback");
    rd(4'd0, b); check({24'b0, b}, 32'h00, "R10 soft por reads zero");
    rd(4'd1, b); check({24'b0, b}, 32'h00, "R10 soft xir reads zero");
    rd(4'd11, b); check({24'b0, b[7:6]}, 32'h0, "R10 xsrc reserved");

    finish_run();
  end
endmodule